// File: doc/BRIEF.md
# Completion-Based Clock Rate Calibrator

This controller keeps a clock generator running as fast as a datapath allows. The datapath signals when a known worst-case operand pair enters it. A fixed number of cycles later, two completion probes report how early the critical result settled. One probe says whether the result settled before the sampling edge minus a slack margin. The other says whether it settled earlier still, with room to spare. From these two bits the controller moves an 8-bit frequency code, which feeds an external DAC and oscillator, by one step up or down, or leaves it where it is.

After reset, and whenever a new calibration is requested, the controller is in calibration mode. The datapath then feeds the worst-case pair repeatedly until a verdict says the rate is right, which ends the mode. Outside that mode the controller still acts on every worst-case pair that occurs in normal traffic. After each code change an inhibit output stays high for a fixed number of cycles so that the datapath does not evaluate while the clock is settling. Operations started in that window, or still in flight when the code moves, are not used.

Top module: `clkcal_ctrl`

## Requirements
- R1: While and after reset, freq_code is RST_CODE (default 128), eval_inhibit is 0 and cal_active is 1.
- R2: The probe bits presented at edge k+LAT (LAT default 2) are used only if wc_flag was 1 and eval_inhibit was 0 at edge k. In every other case they leave freq_code, eval_inhibit and cal_active unchanged.
- R3: A used sample with fin_slack=0 counts as late, because it did not settle outside the margin. It lowers freq_code by exactly 1.
- R4: A used sample with fin_slack=1 and fin_spare=1 raises freq_code by exactly 1.
- R5: A used sample with fin_slack=1 and fin_spare=0 lies in the stop band. It leaves freq_code unchanged, does not raise eval_inhibit and clears cal_active.
- R6: freq_code saturates at 0 and 255. A step past either bound leaves the code unchanged, raises no inhibit, and counts as a stop verdict that clears cal_active.
- R7: Every change of freq_code sets eval_inhibit high starting at that same edge, for exactly HOLD cycles (default 4).
- R8: A change of freq_code discards every operation already in flight. A wc_flag presented while eval_inhibit is high is dropped.
- R9: cal_req sets cal_active on the next edge and wins over a stop verdict at the same edge. Outside calibration, used samples still step the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wc_flag | input | 1 | Worst-case operand pair launched this cycle |
| fin_slack | input | 1 | Result settled before sampling edge minus slack margin |
| fin_spare | input | 1 | Result settled with spare time beyond the margin band |
| cal_req | input | 1 | Start a calibration run |
| freq_code | output | 8 | Oscillator rate code for the DAC |
| eval_inhibit | output | 1 | Datapath must not evaluate; clock is changing |
| cal_active | output | 1 | Calibration in progress; feed worst-case pairs |

## Verification
Directed sequences give the three verdicts one at a time: late, stop band and spare. Together they show direction, step size and the exit from calibration. Samples without a flag, back-to-back flags and a flag raised during the inhibit window show whether qualification and flushing work. Long runs of one verdict drive the code into both bounds, which separates saturation from wrapping. A calibration request that lands on the same edge as a stop verdict shows which of the two wins. A seeded random phase then mixes flag density, verdicts and requests, and each cycle is compared against a bench model computed from the requirements.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_SLOW = 2'd1,
    VERD_HOLD = 2'd2,
    VERD_FAST = 2'd3
  } verdict_t;
endpackage

// File: rtl/clkcal_tag_pipe.sv
module clkcal_tag_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic tag_in,
  output logic tag_out
);
  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || flush) stage_q <= '0;
        else              stage_q <= tag_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || flush) stage_q <= '0;
        else              stage_q <= {stage_q[DEPTH-2:0], tag_in};
      end
    end
  endgenerate

  assign tag_out = stage_q[DEPTH-1];
endmodule

// File: rtl/clkcal_judge.sv
module clkcal_judge
  import clkcal_pkg::*;
(
  input  logic     valid,
  input  logic     fin_slack,
  input  logic     fin_spare,
  output verdict_t verdict
);
  always_comb begin
    if (!valid)          verdict = VERD_NONE;
    else if (!fin_slack) verdict = VERD_SLOW;
    else if (fin_spare)  verdict = VERD_FAST;
    else                 verdict = VERD_HOLD;
  end
endmodule

// File: rtl/clkcal_stepper.sv
module clkcal_stepper
  import clkcal_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int RST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  verdict_t          verdict,
  output logic [CODE_W-1:0] code,
  output logic              changed,
  output logic              stop
);
  localparam logic [CODE_W-1:0] CODE_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RST_CODE);

  logic at_min, at_max;
  assign at_min = (code == '0);
  assign at_max = (code == CODE_MAX);

  always_comb begin
    changed = 1'b0;
    stop    = 1'b0;
    unique case (verdict)
      VERD_SLOW: begin changed = !at_min; stop = at_min; end
      VERD_FAST: begin changed = !at_max; stop = at_max; end
      VERD_HOLD: stop = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) code <= CODE_INIT;
    else if (changed) begin
      if (verdict == VERD_SLOW) code <= code - 1'b1;
      else                      code <= code + 1'b1;
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1)); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(code) == '0) |-> (code != CODE_MAX)); // R6
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(code) == CODE_MAX) |-> (code != '0)); // R6
endmodule

// File: rtl/clkcal_settle.sv
module clkcal_settle #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic inhibit
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      inhibit <= 1'b0;
    end else if (start) begin
      left_q  <= CNT_LOAD;
      inhibit <= 1'b1;
    end else if (left_q > 1) begin
      left_q  <= left_q - 1'b1;
    end else if (left_q == 1) begin
      left_q  <= '0;
      inhibit <= 1'b0;
    end
  end

  AST_INH_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
    inhibit == (left_q != '0)); // R7
endmodule

// File: rtl/clkcal_ctrl.sv
module clkcal_ctrl
  import clkcal_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int RST_CODE = 128,
  parameter int LAT      = 2,
  parameter int HOLD     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wc_flag,
  input  logic              fin_slack,
  input  logic              fin_spare,
  input  logic              cal_req,
  output logic [CODE_W-1:0] freq_code,
  output logic              eval_inhibit,
  output logic              cal_active
);
  logic     tag_due;
  logic     code_moved;
  logic     stop_seen;
  verdict_t verdict;

  clkcal_tag_pipe #(.DEPTH(LAT)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .flush   (code_moved),
    .tag_in  (wc_flag & ~eval_inhibit),
    .tag_out (tag_due)
  );

  clkcal_judge u_judge (
    .valid     (tag_due),
    .fin_slack (fin_slack),
    .fin_spare (fin_spare),
    .verdict   (verdict)
  );

  clkcal_stepper #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_step (
    .clk     (clk),
    .rst     (rst),
    .verdict (verdict),
    .code    (freq_code),
    .changed (code_moved),
    .stop    (stop_seen)
  );

  clkcal_settle #(.HOLD(HOLD)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .start   (code_moved),
    .inhibit (eval_inhibit)
  );

  always_ff @(posedge clk) begin
    if (rst)            cal_active <= 1'b1;
    else if (cal_req)   cal_active <= 1'b1;
    else if (stop_seen) cal_active <= 1'b0;
  end

  AST_NO_TAG_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !$past(tag_due) |-> (freq_code == $past(freq_code))); // R2
  AST_MOVE_RAISES_INH: assert property (@(posedge clk) disable iff (rst)
    (freq_code != $past(freq_code)) |-> eval_inhibit); // R7
  AST_FROZEN_IN_INH: assert property (@(posedge clk) disable iff (rst)
    $past(eval_inhibit) |-> (freq_code == $past(freq_code))); // R8
  AST_STOP_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(cal_active) && !cal_active) |-> (freq_code == $past(freq_code))); // R5
  AST_REQ_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $past(cal_req) |-> cal_active); // R9
endmodule

// File: tb/clkcal_ctrl_tb.sv
module clkcal_ctrl_tb;
  localparam int CW   = 8;
  localparam int RSTC = 128;
  localparam int LAT  = 2;
  localparam int HOLD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wc = 1'b0, sl = 1'b0, sp = 1'b0, rq = 1'b0;
  logic [CW-1:0] code;
  logic inh, act;

  always #4 clk = ~clk;

  clkcal_ctrl #(.CODE_W(CW), .RST_CODE(RSTC), .LAT(LAT), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .wc_flag(wc), .fin_slack(sl), .fin_spare(sp),
    .cal_req(rq), .freq_code(code), .eval_inhibit(inh), .cal_active(act));

  int errs = 0, checks = 0;
  string cur_req = "R1";
  int m_code, m_cnt;
  bit m_inh, m_act;
  bit [LAT-1:0] m_tag;

  task automatic chk(string r, string what, int a, int e);
    checks++;
    if (a != e) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, a, e);
    end
  endtask

  task automatic compare();
    chk(cur_req, "freq_code", int'(code), m_code);
    chk("R7", "eval_inhibit", int'(inh), int'(m_inh));
    chk(cur_req, "cal_active", int'(act), int'(m_act));
  endtask

  task automatic model_step(bit w, bit s, bit p, bit q);
    bit chg = 1'b0, stp = 1'b0;
    int nc = m_code;
    if (m_tag[LAT-1]) begin
      if (!s) begin if (m_code > 0) begin nc = m_code - 1; chg = 1'b1; end else stp = 1'b1; end
      else if (p) begin if (m_code < 255) begin nc = m_code + 1; chg = 1'b1; end else stp = 1'b1; end
      else stp = 1'b1;
    end
    if (chg) m_tag = '0;
    else     m_tag = {m_tag[LAT-2:0], w & ~m_inh};
    if (chg) begin m_cnt = HOLD; m_inh = 1'b1; end
    else if (m_cnt > 1) m_cnt--;
    else if (m_cnt == 1) begin m_cnt = 0; m_inh = 1'b0; end
    if (q) m_act = 1'b1;
    else if (stp) m_act = 1'b0;
    m_code = nc;
  endtask

  task automatic tick(bit w, bit s, bit p, bit q);
    wc = w; sl = s; sp = p; rq = q;
    model_step(w, s, p, q);
    @(negedge clk);
    compare();
  endtask

  task automatic run_op(bit s, bit p);
    tick(1'b1, s, p, 1'b0);
    for (int i = 0; i < LAT + HOLD + 1; i++) tick(1'b0, s, p, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values while reset is held
    chk("R1", "freq_code in reset", int'(code), RSTC);
    chk("R1", "eval_inhibit in reset", int'(inh), 0);
    chk("R1", "cal_active in reset", int'(act), 1);
    rst = 1'b0;
    m_code = RSTC; m_cnt = 0; m_inh = 1'b0; m_act = 1'b1; m_tag = '0;

    cur_req = "R5";
    run_op(1'b1, 1'b0);
    chk("R5", "stop keeps code", int'(code), RSTC);
    chk("R5", "stop ends calibration", int'(act), 0);

    cur_req = "R3";
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3", "late lowers code", int'(code), RSTC - 1);
    chk("R7", "inhibit after change", int'(inh), 1);
    for (int i = 0; i < HOLD; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "inhibit released after hold", int'(inh), 0);

    cur_req = "R4";
    run_op(1'b1, 1'b1);
    chk("R4", "spare raises code", int'(code), RSTC);
    chk("R9", "in-situ step leaves cal_active low", int'(act), 0);

    cur_req = "R2";
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2", "unflagged samples ignored", int'(code), RSTC);

    cur_req = "R8";
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "in-flight op flushed", int'(code), RSTC - 1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "flag during inhibit dropped", int'(code), RSTC - 2);

    cur_req = "R9";
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9", "request sets cal_active", int'(act), 1);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9", "request wins over stop", int'(act), 1);
    run_op(1'b1, 1'b0);
    chk("R9", "later stop ends calibration", int'(act), 0);

    cur_req = "R6";
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    while (m_code > 0) run_op(1'b0, 1'b0);
    chk("R6", "reached floor", int'(code), 0);
    chk("R6", "still calibrating at floor", int'(act), 1);
    run_op(1'b0, 1'b0);
    chk("R6", "no wrap below zero", int'(code), 0);
    chk("R6", "blocked step ends calibration", int'(act), 0);
    while (m_code < 255) run_op(1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6", "no wrap above max", int'(code), 255);
    chk("R6", "no inhibit on blocked step", int'(inh), 0);
    chk("R6", "ceiling ends calibration", int'(act), 0);

    cur_req = "R3";
    for (int i = 0; i < 4000; i++)
      tick(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 2) == 1, ($urandom % 97) == 0);

    summary();
    $finish;
  end
endmodule